// File: doc/BRIEF.md
# Switchable DC-Balance Frame Deserializer

This block takes three serial lanes and turns them back into one 21-bit parallel word, with 7 bits from each lane. The bit-rate sampling strobe `bit_en` and the frame-start marker `frame_start` come from outside the block. A mode input selects one of two line formats. In the plain format a lane sends 7 data bits per frame. In the balanced format a lane sends 9 bits per frame: the 7 data bits followed by a pair of control bits. The control bits tell the receiver whether the sender inverted the 7 data bits to keep the line DC-free. The block undoes that inversion, so downstream logic always sees the true data.

All lanes load the parallel register together, once per frame. The register then holds its value for the whole next frame. A frame-rate output clock reaches its configured active edge in the middle of that hold window, so a receiver can capture on the rising edge or on the falling edge, as configured. A power-enable input disables the outputs. In the plain format, per-lane and clock "undriven" status inputs force the affected data low as a fail-safe.

Top module: `dcb_deser`

## Requirements
- R1: While reset is held, `par_data` is 0, `lane_err` is 0 and `par_clk` sits at its inactive level (0 when `strobe_rise`=1, 1 when `strobe_rise`=0). Reset is asserted asynchronously and released after two clock edges.
- R2: With `dcb_mode`=0, each lane frame is 7 bits sent LSB first. Lane 0 lands in `par_data[6:0]`, lane 1 in `par_data[13:7]` and lane 2 in `par_data[20:14]`.
- R3: With `dcb_mode`=1, each lane frame is 9 bits: data bits 0..6, then control bit A, then control bit B. A pair of (A,B)=(0,1) passes the data through as received.
- R4: A control pair of (A,B)=(1,0) makes the block invert the 7 received data bits before presenting them.
- R5: A control pair of (0,0) or (1,1) sets that lane's bit of `lane_err` and passes the data unmodified. The flag stays set until reset. Plain frames never set it.
- R6: `par_data` and `lane_err` change only at the clock edge that follows the edge sampling a frame's final bit. They are held at every other edge.
- R7: `frame_start` restarts the bit position at 0, even in the middle of a frame. Sampled bits that arrive after a complete frame and before the next `frame_start` are ignored.
- R8: A cycle with `bit_en`=0 samples nothing. The serial value in that cycle has no effect.
- R9: With `pwr_on`=0, `par_oe`, `par_data` and `par_clk` are all 0. The held word reappears when `pwr_on` returns to 1.
- R10: With `dcb_mode`=0, `lane_undriven[i]`=1 forces lane i's 7 output bits to 0, and `clk_undriven`=1 forces all 21 bits to 0. Both take effect without waiting for a clock edge.
- R11: With `dcb_mode`=1, the undriven status inputs have no effect on `par_data`.
- R12: After each parallel load, `par_clk` is at its inactive level. It moves to its active level (1 when `strobe_rise`=1, 0 otherwise) at the edge that samples bit index 3 of a plain frame or bit index 4 of a balanced frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Sample enable for the serial lanes |
| frame_start | input | 1 | Marks the first bit of a frame |
| dcb_mode | input | 1 | 1 = 9-bit balanced format, 0 = 7-bit plain format |
| pwr_on | input | 1 | 0 disables all outputs |
| strobe_rise | input | 1 | 1 = active output clock edge is rising, 0 = falling |
| ser_in | input | 3 | One serial bit per lane |
| lane_undriven | input | 3 | Per-lane undriven status |
| clk_undriven | input | 1 | Clock-input undriven status |
| par_data | output | 21 | Recovered parallel word |
| par_oe | output | 1 | Output enable |
| par_clk | output | 1 | Frame-rate output clock |
| lane_err | output | 3 | Sticky illegal control-pair flags |

## Verification
The bench drives each bit on a falling edge. The parallel word and error flags are due one rising edge after the edge that samples a frame's last bit. The bench checks the old word just after the last-bit edge and the new one just after the following edge. The output clock is checked just after the edge that samples the middle bit, and again after each load. Fail-safe and power-down results are combinational, so they are checked 1 ns after the status inputs change, with no clock in between. The sweeps go over all 128 data values in both formats, with mixed control pairs and both strobe settings.

// File: rtl/dcb_deser_pkg.sv
package dcb_deser_pkg;

  typedef enum logic [1:0] {
    PAIR_ZERO  = 2'b00,
    PAIR_PLAIN = 2'b01,
    PAIR_INV   = 2'b10,
    PAIR_ONES  = 2'b11
  } ctrl_pair_e;

  function automatic logic pair_illegal(input logic [1:0] pair);
    return (pair == PAIR_ZERO) || (pair == PAIR_ONES);
  endfunction

endpackage

// File: rtl/dcb_frame_timer.sv
module dcb_frame_timer #(
  parameter int unsigned DATA_W = 7,
  parameter int unsigned CTRL_W = 2,
  localparam int unsigned FRAME_MAX = DATA_W + CTRL_W,
  localparam int unsigned CNT_W = $clog2(FRAME_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             frame_start,
  input  logic             dcb_mode,
  output logic             cap_en,
  output logic [CNT_W-1:0] cap_idx,
  output logic             mid_hit,
  output logic             frame_done
);

  logic [CNT_W-1:0] len;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;

  always_comb begin
    len     = dcb_mode ? CNT_W'(FRAME_MAX) : CNT_W'(DATA_W);
    cap_en  = bit_en && (frame_start || (cnt_q < len));
    cap_idx = frame_start ? '0 : cnt_q;
    cnt_d   = cap_idx + CNT_W'(1);
    done_d  = cap_en && (cap_idx == (len - CNT_W'(1)));
    mid_hit = cap_en && (cap_idx == (len >> 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      if (cap_en) cnt_q <= cnt_d;
      done_q <= done_d;
    end
  end

  assign frame_done = done_q;

  a_r7_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(FRAME_MAX));

  a_r8_idle_no_advance: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(cnt_q));

endmodule

// File: rtl/dcb_lane_rx.sv
module dcb_lane_rx
  import dcb_deser_pkg::*;
#(
  parameter int unsigned DATA_W = 7,
  parameter int unsigned CTRL_W = 2,
  localparam int unsigned FRAME_MAX = DATA_W + CTRL_W,
  localparam int unsigned CNT_W = $clog2(FRAME_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [CNT_W-1:0]  cap_idx,
  input  logic              ser,
  input  logic              dcb_mode,
  output logic [DATA_W-1:0] data,
  output logic              bad
);

  logic [FRAME_MAX-1:0] shift_q, shift_d;
  logic [1:0]           pair;
  logic [DATA_W-1:0]    raw;

  always_comb begin
    shift_d = shift_q;
    for (int k = 0; k < int'(FRAME_MAX); k++) begin
      if (cap_en && (cap_idx == CNT_W'(k))) shift_d[k] = ser;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else if (cap_en) shift_q <= shift_d;
  end

  always_comb begin
    raw  = shift_q[DATA_W-1:0];
    pair = {shift_q[DATA_W], shift_q[DATA_W+1]};
    data = (dcb_mode && (pair == PAIR_INV)) ? ~raw : raw;
    bad  = dcb_mode && pair_illegal(pair);
  end

endmodule

// File: rtl/dcb_out_stage.sv
module dcb_out_stage #(
  parameter int unsigned LANES  = 3,
  parameter int unsigned DATA_W = 7,
  localparam int unsigned OUT_W = LANES * DATA_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_done,
  input  logic             mid_hit,
  input  logic [OUT_W-1:0] lane_data,
  input  logic [LANES-1:0] lane_bad,
  input  logic             dcb_mode,
  input  logic             pwr_on,
  input  logic             strobe_rise,
  input  logic [LANES-1:0] lane_undriven,
  input  logic             clk_undriven,
  output logic [OUT_W-1:0] par_data,
  output logic             par_oe,
  output logic             par_clk,
  output logic [LANES-1:0] lane_err
);

  logic [OUT_W-1:0] data_q, data_d;
  logic [LANES-1:0] err_q, err_d;
  logic             rclk_q, rclk_d;
  logic [LANES-1:0] keep;

  always_comb begin
    data_d = frame_done ? lane_data : data_q;
    err_d  = err_q | (frame_done ? lane_bad : '0);
    if (frame_done)   rclk_d = 1'b0;
    else if (mid_hit) rclk_d = 1'b1;
    else              rclk_d = rclk_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      err_q  <= '0;
      rclk_q <= 1'b0;
    end else begin
      if (frame_done) begin
        data_q <= data_d;
        err_q  <= err_d;
      end
      rclk_q <= rclk_d;
    end
  end

  for (genvar l = 0; l < int'(LANES); l++) begin : g_mask
    assign keep[l] = pwr_on && (dcb_mode || !(clk_undriven || lane_undriven[l]));
    assign par_data[l*DATA_W +: DATA_W] = keep[l] ? data_q[l*DATA_W +: DATA_W] : '0;
  end

  assign par_oe   = pwr_on;
  assign par_clk  = pwr_on && (strobe_rise ? rclk_q : !rclk_q);
  assign lane_err = err_q;

  a_r5_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_err != '0) |=> ((lane_err & $past(lane_err)) == $past(lane_err)));

  a_r6_hold_between_loads: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_done |=> ($stable(data_q) && $stable(lane_err)));

  a_r9_powered_down: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_on |-> (!par_oe && (par_data == '0) && !par_clk));

  a_r11_no_failsafe_balanced: assert property (@(posedge clk) disable iff (!rst_n)
    (dcb_mode && pwr_on) |-> (par_data == data_q));

  a_r12_clk_idle_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !rclk_q);

endmodule

// File: rtl/dcb_deser.sv
module dcb_deser #(
  parameter int unsigned LANES  = 3,
  parameter int unsigned DATA_W = 7,
  parameter int unsigned CTRL_W = 2,
  localparam int unsigned OUT_W = LANES * DATA_W,
  localparam int unsigned CNT_W = $clog2(DATA_W + CTRL_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             frame_start,
  input  logic             dcb_mode,
  input  logic             pwr_on,
  input  logic             strobe_rise,
  input  logic [LANES-1:0] ser_in,
  input  logic [LANES-1:0] lane_undriven,
  input  logic             clk_undriven,
  output logic [OUT_W-1:0] par_data,
  output logic             par_oe,
  output logic             par_clk,
  output logic [LANES-1:0] lane_err
);

  logic [1:0]       rst_sync_q;
  logic             rst_ni;
  logic             cap_en, mid_hit, frame_done;
  logic [CNT_W-1:0] cap_idx;
  logic [OUT_W-1:0] lane_data;
  logic [LANES-1:0] lane_bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  dcb_frame_timer #(.DATA_W(DATA_W), .CTRL_W(CTRL_W)) u_timer (
    .clk(clk), .rst_n(rst_ni), .bit_en(bit_en), .frame_start(frame_start),
    .dcb_mode(dcb_mode), .cap_en(cap_en), .cap_idx(cap_idx),
    .mid_hit(mid_hit), .frame_done(frame_done)
  );

  for (genvar l = 0; l < int'(LANES); l++) begin : g_lane
    dcb_lane_rx #(.DATA_W(DATA_W), .CTRL_W(CTRL_W)) u_lane (
      .clk(clk), .rst_n(rst_ni), .cap_en(cap_en), .cap_idx(cap_idx),
      .ser(ser_in[l]), .dcb_mode(dcb_mode),
      .data(lane_data[l*DATA_W +: DATA_W]), .bad(lane_bad[l])
    );
  end

  dcb_out_stage #(.LANES(LANES), .DATA_W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_ni), .frame_done(frame_done), .mid_hit(mid_hit),
    .lane_data(lane_data), .lane_bad(lane_bad), .dcb_mode(dcb_mode),
    .pwr_on(pwr_on), .strobe_rise(strobe_rise), .lane_undriven(lane_undriven),
    .clk_undriven(clk_undriven), .par_data(par_data), .par_oe(par_oe),
    .par_clk(par_clk), .lane_err(lane_err)
  );

endmodule

// File: tb/sim_dcb_deser.sv
`timescale 1ns/1ps
module sim_dcb_deser;

  logic        clk = 1'b0;
  logic        rst_n, bit_en, frame_start, dcb_mode, pwr_on, strobe_rise, clk_undriven;
  logic [2:0]  ser_in, lane_undriven;
  logic [20:0] par_data;
  logic        par_oe, par_clk;
  logic [2:0]  lane_err;

  int checks = 0;
  int fails  = 0;
  logic [20:0] exp_word;
  logic [2:0]  exp_err;

  always #2.5 clk = ~clk;

  dcb_deser u0 (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .frame_start(frame_start),
    .dcb_mode(dcb_mode), .pwr_on(pwr_on), .strobe_rise(strobe_rise),
    .ser_in(ser_in), .lane_undriven(lane_undriven), .clk_undriven(clk_undriven),
    .par_data(par_data), .par_oe(par_oe), .par_clk(par_clk), .lane_err(lane_err)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(par_data == '0, "R1 data", 32'(par_data), 0);
    chk(lane_err == '0, "R1 err", 32'(lane_err), 0);
    chk(par_clk == !strobe_rise, "R1 clk", 32'(par_clk), 32'(!strobe_rise));
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    exp_word = '0;
    exp_err  = '0;
  endtask

  function automatic logic [6:0] lane_exp(input logic [6:0] d, input logic [1:0] p, input bit m);
    return (m && p == 2'b10) ? ~d : d;
  endfunction

  function automatic logic frame_bit(input logic [6:0] d, input logic [1:0] p, input int i);
    if (i < 7) return d[i];
    return (i == 7) ? p[1] : p[0];
  endfunction

  // Send one frame, with optional idle cycles carrying junk between bits (R8).
  task automatic send_frame(input logic [6:0] d0, d1, d2, input logic [1:0] p0, p1, p2,
                            input bit m, input bit gap);
    int len = m ? 9 : 7;
    int mid = len / 2;
    logic [20:0] nw;
    dcb_mode = m;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (i == mid)     chk(par_clk == !strobe_rise, "R12 pre-mid", 32'(par_clk), 32'(!strobe_rise));
      if (i == mid + 1) chk(par_clk == strobe_rise, "R12 mid", 32'(par_clk), 32'(strobe_rise));
      if (gap && i > 0) begin
        bit_en = 1'b0; frame_start = 1'b0;
        ser_in = ~{frame_bit(d2, p2, i), frame_bit(d1, p1, i), frame_bit(d0, p0, i)};
        @(negedge clk);
      end
      bit_en = 1'b1;
      frame_start = (i == 0);
      ser_in = {frame_bit(d2, p2, i), frame_bit(d1, p1, i), frame_bit(d0, p0, i)};
    end
    @(negedge clk);
    bit_en = 1'b0; frame_start = 1'b0; ser_in = '0;
    chk(par_data == exp_word, "R6 held", 32'(par_data), 32'(exp_word));
    nw = {lane_exp(d2, p2, m), lane_exp(d1, p1, m), lane_exp(d0, p0, m)};
    if (m) begin
      exp_err[0] |= (p0 == 2'b00 || p0 == 2'b11);
      exp_err[1] |= (p1 == 2'b00 || p1 == 2'b11);
      exp_err[2] |= (p2 == 2'b00 || p2 == 2'b11);
    end
    exp_word = nw;
    @(negedge clk);
    chk(par_data == exp_word, m ? "R3 R4 word" : "R2 word", 32'(par_data), 32'(exp_word));
    chk(lane_err == exp_err, "R5 err", 32'(lane_err), 32'(exp_err));
    chk(par_clk == !strobe_rise, "R12 after load", 32'(par_clk), 32'(!strobe_rise));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    bit_en = 0; frame_start = 0; dcb_mode = 0; pwr_on = 1; strobe_rise = 1;
    ser_in = 0; lane_undriven = 0; clk_undriven = 0;
    do_reset();

    // R2: all plain values, both strobe settings
    for (int v = 0; v < 128; v++) begin
      strobe_rise = v[2];
      send_frame(7'(v), 7'(v) ^ 7'h2A, ~7'(v), 2'b01, 2'b01, 2'b01, 1'b0, 1'b0);
    end
    // R3 R4: balanced, mixed legal pairs
    for (int v = 0; v < 128; v++) begin
      strobe_rise = v[3];
      send_frame(7'(v), 7'(v) ^ 7'h55, 7'(v * 3),
                 v[0] ? 2'b10 : 2'b01, v[0] ? 2'b01 : 2'b10, v[1] ? 2'b10 : 2'b01, 1'b1, 1'b0);
    end
    strobe_rise = 1'b1;
    // R8: idle cycles with junk between sampled bits
    send_frame(7'h5A, 7'h13, 7'h7E, 2'b10, 2'b01, 2'b10, 1'b1, 1'b1);
    send_frame(7'h21, 7'h4C, 7'h0F, 2'b01, 2'b01, 2'b01, 1'b0, 1'b1);

    // R7: partial frame restarted by frame_start
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); bit_en = 1; frame_start = (i == 0); ser_in = 3'b111;
    end
    send_frame(7'h00, 7'h11, 7'h22, 2'b01, 2'b01, 2'b01, 1'b0, 1'b0);
    // R7: trailing bits without frame_start are ignored
    for (int i = 0; i < 12; i++) begin
      @(negedge clk); bit_en = 1; frame_start = 0; ser_in = 3'(i);
    end
    @(negedge clk); bit_en = 0;
    repeat (3) @(negedge clk);
    chk(par_data == exp_word, "R7 trailing ignored", 32'(par_data), 32'(exp_word));

    // R10: fail-safe sweep in plain mode
    for (int u = 0; u < 16; u++) begin
      logic [20:0] e;
      lane_undriven = 3'(u); clk_undriven = u[3];
      #1;
      e = exp_word;
      for (int l = 0; l < 3; l++) if (u[3] || u[l]) e[l*7 +: 7] = '0;
      chk(par_data == e, "R10 failsafe", 32'(par_data), 32'(e));
    end
    // R11: ignored in balanced mode
    dcb_mode = 1'b1;
    #1;
    chk(par_data == exp_word, "R11 balanced ignores failsafe", 32'(par_data), 32'(exp_word));
    lane_undriven = 3'b101; clk_undriven = 1'b0;
    #1;
    chk(par_data == exp_word, "R11 lane status ignored", 32'(par_data), 32'(exp_word));
    lane_undriven = '0; dcb_mode = 1'b0;

    // R9: power-down and restore
    @(negedge clk); pwr_on = 1'b0;
    #1;
    chk(par_oe == 1'b0, "R9 oe", 32'(par_oe), 0);
    chk(par_data == '0, "R9 data", 32'(par_data), 0);
    chk(par_clk == 1'b0, "R9 clk", 32'(par_clk), 0);
    strobe_rise = 1'b0;
    #1;
    chk(par_clk == 1'b0, "R9 clk falling mode", 32'(par_clk), 0);
    pwr_on = 1'b1; strobe_rise = 1'b1;
    #1;
    chk(par_oe == 1'b1 && par_data == exp_word, "R9 restore", 32'(par_data), 32'(exp_word));

    // R5: illegal pairs, stickiness, clear on reset
    send_frame(7'h3C, 7'h6A, 7'h01, 2'b01, 2'b00, 2'b10, 1'b1, 1'b0);
    send_frame(7'h12, 7'h34, 7'h56, 2'b01, 2'b01, 2'b01, 1'b1, 1'b0);
    send_frame(7'h70, 7'h07, 7'h2B, 2'b10, 2'b01, 2'b11, 1'b1, 1'b0);
    send_frame(7'h44, 7'h55, 7'h66, 2'b00, 2'b11, 2'b00, 1'b0, 1'b0);
    do_reset();
    chk(lane_err == '0, "R5 cleared by reset", 32'(lane_err), 0);
    send_frame(7'h19, 7'h2E, 7'h73, 2'b11, 2'b10, 2'b01, 1'b1, 1'b0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule